// File: doc/BRIEF.md
# Eight-bit multi-mode timer with PWM outputs

An 8-bit timer/counter for a microcontroller-style peripheral. The count advances on ticks from a prescaler, which passes the system clock undivided or divided by a selectable ratio, or holds the count still. A two-bit mode field selects one of four behaviours of a single counter. Normal mode counts up and wraps. Clear-on-compare mode returns to zero after the count equals compare register A. Fast PWM produces a sawtooth with edge-aligned pulses. Phase-correct PWM runs a triangle, up and then down, with pulses centred on the bottom of the count.

Two compare channels, A and B, each have a compare register and a waveform output. Overflow, compare-A and compare-B events set sticky flags that software clears by writing 1, and each flag drives an interrupt line. A flat register port with a write enable, an address and a combinational read mux gives software access to the control fields, the count, both compare registers and the flags. In the PWM modes, compare writes land in a buffer, and the buffer takes effect only at the top of the count, so a pulse is never glitched mid-period.

Top module: `tmr8_pwm_timer`

## Requirements
- R1: After reset every register reads 0 (timer stopped, normal mode), and all flags, interrupt lines and waveform outputs are 0.
- R2: Control bits [2:0] select the prescaler: 0 stopped, 1 every clock, 2 every 8th, 3 every 64th, 4 every 256th, 5 every 1024th (6 and 7 stopped). Writing a different select value restarts the divider, so with select 2 the first count step falls on the 8th clock after the write.
- R3: Normal mode (mode 0) counts up by one per tick, wraps from 255 to 0, and sets the overflow flag (flags bit 0) at the wrap.
- R4: The register map is: address 0 control (select [2:0], mode [4:3]), 1 count, 2 compare A, 3 compare B, 4 flags (bit 0 overflow, bit 1 compare A, bit 2 compare B). Flags are sticky. Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. Reads are combinational on the address.
- R5: Clear-on-compare mode (mode 1) returns the count to 0 on the tick taken while the count equals compare A.
- R6: A compare flag is set on every tick at which the count equals that channel's compare value, in any mode. In modes 0 and 1 the channel's waveform output toggles on each such match.
- R7: Fast PWM mode (mode 2) counts 0 to 255 and wraps. The output goes high at the wrap and low on the match, so compare value k gives k+1 high ticks per 256: 0 gives a one-tick pulse and 255 holds the output high.
- R8: Phase-correct mode (mode 3) counts up to 255, turns to 254, counts down to 0 and turns to 1, for a 510-tick period. The output falls on the up-slope match and rises on the down-slope match, giving 2k high ticks centred on the bottom. Compare 0 holds it low, compare 255 holds it high, and the overflow flag is set as the count reaches 0.
- R9: In modes 2 and 3 a compare write goes to a buffer, which reads back at once but only becomes active at the top of the count. In modes 0 and 1 the write is active immediately.
- R10: A write to the count register loads it directly, taking priority over a tick, and no compare match is taken on that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| irq_ovf_o | output | 1 | Overflow flag |
| irq_cmpa_o | output | 1 | Compare A flag |
| irq_cmpb_o | output | 1 | Compare B flag |
| wave_a_o | output | 1 | Waveform output of channel A |
| wave_b_o | output | 1 | Waveform output of channel B |

## Verification
The counter is started just below the wrap from a known loaded value, so the wrap, the CTC clear and the phase-correct turning points fall on cycles the bench can predict. Duty is measured by counting high samples over exactly one period for compare values 0, a small value, a mid value and 255. These counts tell a one-tick pulse from a held-low output, and the 2k centred pulse from the k+1 edge-aligned pulse. Writing compare A in the middle of a fast-PWM period and measuring the rest of that period separates buffered from direct update. A count write timed onto the tick at which a match would occur shows that the load suppresses the match. The /8 divider is checked one clock before and at the expected step.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_CTC    = 2'd1,
    MODE_FAST   = 2'd2,
    MODE_PHASE  = 2'd3
  } tmr_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd4;
  localparam int N_CHAN = 2;
  localparam int SEL_W  = 3;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
#(
  parameter int DIV_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] last;
  logic             run;

  always_comb begin
    case (sel_i)
      3'd2:    last = DIV_W'(7);
      3'd3:    last = DIV_W'(63);
      3'd4:    last = DIV_W'(255);
      3'd5:    last = DIV_W'(1023);
      default: last = '0;
    endcase
  end

  assign run    = (sel_i != '0) && (sel_i <= 3'd5);
  assign tick_o = run && (div_q == last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run)       div_q <= tick_o ? '0 : div_q + 1'b1;
  end

  // R2: divide-by-8 never yields back-to-back ticks
  a_r2_div8_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i == 3'd2 && !restart_i) |=> !tick_o);
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  tmr_mode_e        mode_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic [CNT_W-1:0] ctc_top_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             up_o,
  output logic             ovf_evt_o,
  output logic             top_evt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic             adv;

  assign adv = tick_i && !load_i;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (load_i) begin
      cnt_d = load_val_i;
    end else if (tick_i) begin
      case (mode_i)
        MODE_CTC:   cnt_d = (cnt_q == ctc_top_i) ? '0 : cnt_q + 1'b1;
        MODE_PHASE: begin
          if (up_q) begin
            if (cnt_q == CNT_MAX) begin
              up_d  = 1'b0;
              cnt_d = cnt_q - 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == '0) begin
              up_d  = 1'b1;
              cnt_d = cnt_q + 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default:    cnt_d = cnt_q + 1'b1;
      endcase
    end
    if (mode_i != MODE_PHASE) up_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign ovf_evt_o = adv && ((mode_i != MODE_PHASE && cnt_q == CNT_MAX) ||
                             (mode_i == MODE_PHASE && !up_q && cnt_q == CNT_W'(1)));
  assign top_evt_o = adv && cnt_q == CNT_MAX &&
                     (mode_i == MODE_FAST || (mode_i == MODE_PHASE && up_q));
  assign cnt_o = cnt_q;
  assign up_o  = up_q;

  a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == MODE_NORMAL && cnt_q == CNT_MAX) |=> (cnt_q == '0));
  a_r5_ctc_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == MODE_CTC && cnt_q == ctc_top_i) |=> (cnt_q == '0));
  a_r8_down_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == MODE_PHASE && !up_q && cnt_q != '0)
      |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));
  a_r10_load_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/tmr8_cmp_chan.sv
module tmr8_cmp_chan
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tmr_mode_e        mode_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             up_i,
  input  logic             top_evt_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] buf_o,
  output logic [CNT_W-1:0] act_o,
  output logic             match_o,
  output logic             wave_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] buf_q, act_q, eff;
  logic             wave_q, wave_d, pwm, adv;

  assign pwm     = (mode_i == MODE_FAST) || (mode_i == MODE_PHASE);
  assign adv     = tick_i && !load_i;
  // value being loaded at the top counts already on that tick
  assign eff     = top_evt_i ? buf_q : act_q;
  assign match_o = adv && (cnt_i == eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_i) buf_q <= wdata_i;
      if (wr_i && !pwm)   act_q <= wdata_i;
      else if (top_evt_i) act_q <= buf_q;
    end
  end

  always_comb begin
    wave_d = wave_q;
    if (adv) begin
      case (mode_i)
        MODE_FAST: begin
          if (match_o && eff != CNT_MAX) wave_d = 1'b0;
          else if (cnt_i == CNT_MAX)     wave_d = 1'b1;
        end
        MODE_PHASE: begin
          if (eff == '0)                     wave_d = 1'b0;
          else if (eff == CNT_MAX)           wave_d = 1'b1;
          else if (match_o)                  wave_d = !up_i;
          else if (up_i && cnt_i == CNT_MAX) wave_d = 1'b0;
        end
        default: if (match_o) wave_d = !wave_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_q <= 1'b0;
    else         wave_q <= wave_d;
  end

  assign buf_o  = buf_q;
  assign act_o  = act_q;
  assign wave_o = wave_q;

  a_r9_hold_until_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm && !top_evt_i) |=> $stable(act_q));
  a_r7_full_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv && mode_i == MODE_FAST && eff == CNT_MAX) |=> wave_q);
endmodule

// File: rtl/tmr8_pwm_timer.sv
module tmr8_pwm_timer
  import tmr8_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_ovf_o,
  output logic              irq_cmpa_o,
  output logic              irq_cmpb_o,
  output logic              wave_a_o,
  output logic              wave_b_o
);
  localparam int N_FLAG = N_CHAN + 1;

  logic [SEL_W-1:0]  sel_q;
  tmr_mode_e         mode_q;
  logic [N_FLAG-1:0] flag_q, flag_set, flag_clr;
  logic              wr_ctrl, wr_cnt, wr_flag, restart, tick;
  logic [DATA_W-1:0] cnt;
  logic              up, ovf_evt, top_evt;
  logic [DATA_W-1:0] chan_buf [N_CHAN];
  logic [DATA_W-1:0] chan_act [N_CHAN];
  logic [N_CHAN-1:0] chan_match, chan_wave;

  assign wr_ctrl = wr_en_i && addr_i == ADDR_CTRL;
  assign wr_cnt  = wr_en_i && addr_i == ADDR_CNT;
  assign wr_flag = wr_en_i && addr_i == ADDR_FLAG;
  assign restart = wr_ctrl && wdata_i[SEL_W-1:0] != sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      mode_q <= MODE_NORMAL;
    end else if (wr_ctrl) begin
      sel_q  <= wdata_i[SEL_W-1:0];
      mode_q <= tmr_mode_e'(wdata_i[SEL_W+1:SEL_W]);
    end
  end

  tmr8_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni, .sel_i(sel_q), .restart_i(restart), .tick_o(tick)
  );

  tmr8_core #(.CNT_W(DATA_W)) u_core (
    .clk_i, .rst_ni, .tick_i(tick), .mode_i(mode_q), .load_i(wr_cnt),
    .load_val_i(wdata_i), .ctc_top_i(chan_act[0]), .cnt_o(cnt), .up_o(up),
    .ovf_evt_o(ovf_evt), .top_evt_o(top_evt)
  );

  for (genvar i = 0; i < N_CHAN; i++) begin : g_chan
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_CMPA + ADDR_W'(i);
    tmr8_cmp_chan #(.CNT_W(DATA_W)) u_chan (
      .clk_i, .rst_ni, .mode_i(mode_q), .tick_i(tick), .load_i(wr_cnt),
      .cnt_i(cnt), .up_i(up), .top_evt_i(top_evt),
      .wr_i(wr_en_i && addr_i == MY_ADDR), .wdata_i(wdata_i),
      .buf_o(chan_buf[i]), .act_o(chan_act[i]),
      .match_o(chan_match[i]), .wave_o(chan_wave[i])
    );
  end

  assign flag_set = {chan_match, ovf_evt};
  assign flag_clr = wr_flag ? wdata_i[N_FLAG-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_CTRL:        rdata_o = DATA_W'({mode_q, sel_q});
      ADDR_CNT:         rdata_o = cnt;
      ADDR_CMPA:        rdata_o = chan_buf[0];
      ADDR_CMPA + 3'd1: rdata_o = chan_buf[1];
      ADDR_FLAG:        rdata_o = DATA_W'(flag_q);
      default:          rdata_o = '0;
    endcase
  end

  assign irq_ovf_o  = flag_q[0];
  assign irq_cmpa_o = flag_q[1];
  assign irq_cmpb_o = flag_q[2];
  assign wave_a_o   = chan_wave[0];
  assign wave_b_o   = chan_wave[1];

  a_r4_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] && !(wr_flag && wdata_i[0])) |=> flag_q[0]);
  a_r4_cmpa_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[1] && !(wr_flag && wdata_i[1])) |=> flag_q[1]);
  a_r6_match_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chan_match[1] |=> irq_cmpb_o);
endmodule

// File: tb/sim_tmr8_pwm_timer.sv
module sim_tmr8_pwm_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq_ovf, irq_cmpa, irq_cmpb, wave_a, wave_b;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr8_pwm_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_ovf_o(irq_ovf),
    .irq_cmpa_o(irq_cmpa), .irq_cmpb_o(irq_cmpb),
    .wave_a_o(wave_a), .wave_b_o(wave_b)
  );

  localparam logic [7:0] M_NORM = 8'h00, M_CTC = 8'h08, M_FAST = 8'h10, M_PHASE = 8'h18;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      ha += int'(wave_a);
      hb += int'(wave_b);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk($sformatf("R1 reg %0d after reset", a), v, 0);
    end
    chk("R1 irq lines", int'({irq_ovf, irq_cmpa, irq_cmpb}), 0);
    chk("R1 waves", int'({wave_a, wave_b}), 0);
  endtask

  task automatic t_normal;
    int v;
    wr(3'd1, 8'd250);
    wr(3'd4, 8'h07);
    wr(3'd0, M_NORM | 8'd1);
    rd(3'd0, v);
    chk("R4 ctrl readback", v, 1);
    idle(5);
    rd(3'd1, v);
    chk("R3 count before wrap", v, 255);
    chk("R3 no overflow yet", int'(irq_ovf), 0);
    idle(1);
    rd(3'd1, v);
    chk("R3 wrap to 0", v, 0);
    chk("R3 overflow flag", int'(irq_ovf), 1);
    wr(3'd0, M_NORM);
    wr(3'd4, 8'h06);
    chk("R4 write 0 keeps flag", int'(irq_ovf), 1);
    wr(3'd4, 8'h01);
    chk("R4 write 1 clears flag", int'(irq_ovf), 0);
  endtask

  task automatic t_presc;
    int v;
    wr(3'd1, 8'd0);
    wr(3'd0, M_NORM | 8'd2);
    idle(23);
    rd(3'd1, v);
    chk("R2 /8 count after 23 clocks", v, 2);
    idle(1);
    rd(3'd1, v);
    chk("R2 /8 count after 24 clocks", v, 3);
    wr(3'd0, M_NORM);
    idle(20);
    rd(3'd1, v);
    chk("R2 stopped holds count", v, 3);
  endtask

  task automatic t_ctc;
    int v;
    logic wa0;
    wr(3'd1, 8'd0);
    wr(3'd2, 8'd4);
    wr(3'd3, 8'd200);
    wr(3'd4, 8'h07);
    wa0 = wave_a;
    wr(3'd0, M_CTC | 8'd1);
    idle(4);
    rd(3'd1, v);
    chk("R5 count reaches compare", v, 4);
    chk("R6 no match flag yet", int'(irq_cmpa), 0);
    idle(1);
    rd(3'd1, v);
    chk("R5 cleared after match", v, 0);
    chk("R6 compare A flag", int'(irq_cmpa), 1);
    chk("R6 wave A toggled", int'(wave_a), int'(!wa0));
    idle(2);
    rd(3'd1, v);
    chk("R5 counts on after clear", v, 2);
  endtask

  task automatic t_fast;
    int v, ha, hb;
    wr(3'd0, M_FAST);
    wr(3'd1, 8'd250);
    wr(3'd2, 8'd3);
    wr(3'd3, 8'd0);
    wr(3'd0, M_FAST | 8'd1);
    idle(6);
    rd(3'd1, v);
    chk("R7 wrap to 0", v, 0);
    chk("R7 high at cycle start", int'(wave_a), 1);
    measure(256, ha, hb);
    chk("R7 compare 3 high ticks", ha, 4);
    chk("R7 compare 0 one tick", hb, 1);
    wr(3'd2, 8'd100);
    rd(3'd2, v);
    chk("R9 buffer reads back", v, 100);
    measure(255, ha, hb);
    chk("R9 old compare kept mid-period", ha, 3);
    measure(256, ha, hb);
    chk("R9 new compare after top", ha, 101);
    wr(3'd2, 8'd255);
    measure(255, ha, hb);
    measure(256, ha, hb);
    chk("R7 compare 255 held high", ha, 256);
  endtask

  task automatic t_phase;
    int v, ha, hb;
    wr(3'd0, M_PHASE);
    wr(3'd1, 8'd250);
    wr(3'd2, 8'd10);
    wr(3'd3, 8'd0);
    wr(3'd4, 8'h07);
    wr(3'd0, M_PHASE | 8'd1);
    idle(6);
    rd(3'd1, v);
    chk("R8 turn at top", v, 254);
    chk("R8 no overflow at top", int'(irq_ovf), 0);
    measure(510, ha, hb);
    chk("R8 compare 10 high ticks", ha, 20);
    chk("R8 compare 0 held low", hb, 0);
    rd(3'd1, v);
    chk("R8 period 510", v, 254);
    chk("R8 overflow at bottom", int'(irq_ovf), 1);
    wr(3'd3, 8'd255);
    measure(509, ha, hb);
    measure(510, ha, hb);
    chk("R8 compare 255 held high", hb, 510);
    chk("R8 compare 10 repeat", ha, 20);
  endtask

  task automatic t_load;
    int v;
    wr(3'd0, M_NORM);
    wr(3'd2, 8'd20);
    wr(3'd3, 8'd200);
    wr(3'd1, 8'd19);
    wr(3'd4, 8'h07);
    wr(3'd0, M_NORM | 8'd1);
    idle(1);
    rd(3'd1, v);
    chk("R10 count at compare", v, 20);
    wr(3'd1, 8'd100);
    rd(3'd1, v);
    chk("R10 load wins over tick", v, 100);
    chk("R10 match suppressed", int'(irq_cmpa), 0);
    idle(1);
    rd(3'd1, v);
    chk("R10 counts from loaded value", v, 101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_normal();
    t_presc();
    t_ctc();
    t_fast();
    t_phase();
    t_load();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule